// File: doc/BRIEF.md
# Fixed Off-Time Current-Limit Chopper

This block keeps the load current of an H-bridge within a limit. It does so with a fixed off-time scheme on the low-side switches. A synchronous comparator flag reports that the current is above the limit. When that flag is seen while the bridge is conducting, the block asks the bridge controller to switch every output off for a fixed number of clock cycles. When the off time ends, the outputs follow the inputs again. A blanking window then starts, and the comparator is ignored for its whole length. The off time plus the blanking window sets a lower bound on the chopping period, so the switching rate caused by current limiting stays below a known figure. Chopping raises only a current-limit-active indication and never the fault output.

A second flag, for a much larger current, skips the chopping loop altogether. It forces the outputs off on the next cycle, whatever the chopper is doing. It also sends a single-cycle fault pulse that the controller latches. A saturating counter records how many off periods have started, and a clear strobe sets it back to zero. Both durations are parameters counted in clock cycles. The defaults give 20.5 µs of off time and 16.5 µs of blanking at 50 MHz.

Top module: `ilim_chopper`

## Requirements
- R1: While reset is applied and after it is released, force_off, lim_active and fault_pulse are low and evt_count is zero.
- R2: If over_lim is sampled high while the chopper is conducting and short_det is low, force_off and lim_active go high on the next cycle, and force_off stays high for exactly OFF_CYC cycles.
- R3: After the off period, force_off is low and lim_active stays high for exactly BLANK_CYC cycles. During that window over_lim has no effect: no off period starts and evt_count does not change.
- R4: If over_lim is still high when the blanking window ends, exactly one conducting cycle follows before the next off period starts. Successive off-period starts are therefore at least OFF_CYC+BLANK_CYC+1 cycles apart.
- R5: Chopping alone never raises fault_pulse.
- R6: If short_det is sampled high, force_off is high on the next cycle and stays high while short_det stays high, in any chopper phase. Each rising edge of short_det gives fault_pulse high for exactly one cycle.
- R7: A short_det event during an off period still gives a fault_pulse. The off period ends on the same cycle it would have ended without the event.
- R8: While short_det is high, over_lim cannot start an off period, lim_active stays low if it was low, and evt_count does not change.
- R9: evt_count rises by one on the cycle after each off-period start. It saturates at 2^CNT_W-1.
- R10: A cnt_clr strobe sets evt_count to zero on the next cycle. If an off period starts in the same cycle as the strobe, evt_count becomes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| over_lim | input | 1 | Synchronous flag: load current above the chopping limit |
| short_det | input | 1 | Synchronous flag: short-circuit current detected |
| cnt_clr | input | 1 | Strobe that clears the event counter |
| force_off | output | 1 | Request to the bridge controller to switch all outputs off |
| lim_active | output | 1 | High during an off period and its blanking window |
| fault_pulse | output | 1 | One-cycle pulse on each new short-circuit event |
| evt_count | output | CNT_W | Saturating count of off-period starts |

## Verification
Every result of this block comes from a register. An input sampled at one edge shows up one cycle later: force_off, lim_active, fault_pulse and the evt_count step all follow the triggering edge. The later boundaries fall OFF_CYC cycles after the start (force_off falls), OFF_CYC+BLANK_CYC cycles after it (lim_active falls), and OFF_CYC+BLANK_CYC+1 cycles after it (earliest restart). The bench drives inputs on falling edges and samples outputs on the falling edge just after the rising edge of interest. It counts falling edges from the stimulus and checks both sides of each boundary: the last cycle of a phase and the first cycle after it. Fault pulses are counted on rising edges over whole scenarios, so a chopping run that raises a stray pulse is also caught.

// File: rtl/ilim_pkg.sv
package ilim_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_OFF   = 2'd1,
        PH_BLANK = 2'd2
    } phase_e;

    typedef struct packed {
        logic force_off;
        logic active;
        logic start;
    } chop_s;

    typedef struct packed {
        logic force_off;
        logic fault;
    } short_s;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ilim_phase_fsm.sv
module ilim_phase_fsm
    import ilim_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 1025,
    parameter int unsigned BLANK_CYC = 825
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   over_lim,
    input  logic   inhibit,
    output phase_e phase,
    output chop_s  chop
);
    localparam int unsigned TW = width_for(max_u(OFF_CYC, BLANK_CYC));
    localparam logic [TW-1:0] OFF_LD   = TW'(OFF_CYC - 1);
    localparam logic [TW-1:0] BLANK_LD = TW'(BLANK_CYC - 1);

    phase_e        ph_q, ph_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          go;

    assign go = (ph_q == PH_RUN) && over_lim && !inhibit;

    always_comb begin
        ph_d  = ph_q;
        tmr_d = tmr_q;
        unique case (ph_q)
            PH_RUN: begin
                if (go) begin
                    ph_d  = PH_OFF;
                    tmr_d = OFF_LD;
                end
            end
            PH_OFF: begin
                if (tmr_q == '0) begin
                    ph_d  = PH_BLANK;
                    tmr_d = BLANK_LD;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            PH_BLANK: begin
                if (tmr_q == '0) begin
                    ph_d = PH_RUN;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            default: begin
                ph_d  = PH_RUN;
                tmr_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_RUN;
            tmr_q <= '0;
        end else begin
            ph_q  <= ph_d;
            tmr_q <= tmr_d;
        end
    end

    assign phase          = ph_q;
    assign chop.force_off = (ph_q == PH_OFF);
    assign chop.active    = (ph_q != PH_RUN);
    assign chop.start     = go;

endmodule

// File: rtl/ilim_short_path.sv
module ilim_short_path
    import ilim_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   short_det,
    output short_s sc
);
    logic seen_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            seen_q  <= short_det;
            pulse_q <= short_det && !seen_q;
        end
    end

    assign sc.force_off = seen_q;
    assign sc.fault     = pulse_q;

endmodule

// File: rtl/ilim_evt_counter.sv
module ilim_evt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;

    assign base = clr ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (base != TOP)) begin
            cnt_q <= base + 1'b1;
        end else begin
            cnt_q <= base;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/ilim_chopper.sv
module ilim_chopper
    import ilim_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 1025,
    parameter int unsigned BLANK_CYC = 825,
    parameter int unsigned CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             over_lim,
    input  logic             short_det,
    input  logic             cnt_clr,
    output logic             force_off,
    output logic             lim_active,
    output logic             fault_pulse,
    output logic [CNT_W-1:0] evt_count
);
    phase_e phase;
    chop_s  chop;
    short_s sc;

    ilim_phase_fsm #(
        .OFF_CYC  (OFF_CYC),
        .BLANK_CYC(BLANK_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .over_lim(over_lim),
        .inhibit (short_det),
        .phase   (phase),
        .chop    (chop)
    );

    ilim_short_path u_sc (
        .clk      (clk),
        .rst      (rst),
        .short_det(short_det),
        .sc       (sc)
    );

    ilim_evt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .inc  (chop.start),
        .count(evt_count)
    );

    assign force_off   = chop.force_off | sc.force_off;
    assign lim_active  = chop.active;
    assign fault_pulse = sc.fault;

endmodule

// File: rtl/ilim_chopper_chk.sv
module ilim_chopper_chk
    import ilim_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 1025,
    parameter int unsigned BLANK_CYC = 825,
    parameter int unsigned CNT_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             over_lim,
    input logic             short_det,
    input logic             cnt_clr,
    input logic             force_off,
    input logic             lim_active,
    input logic             fault_pulse,
    input logic [CNT_W-1:0] evt_count,
    input phase_e           phase
);
    localparam int unsigned GAP = OFF_CYC + BLANK_CYC + 1;

    logic        prev_off;
    logic        seen_start;
    int unsigned since;
    int unsigned off_run;
    logic        entry;

    assign entry = (phase == PH_OFF) && !prev_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_off   <= 1'b0;
            seen_start <= 1'b0;
            since      <= 0;
            off_run    <= 0;
        end else begin
            prev_off <= (phase == PH_OFF);
            off_run  <= (phase == PH_OFF) ? off_run + 1 : 0;
            if (entry) begin
                seen_start <= 1'b1;
                since      <= 1;
            end else if (since < GAP) begin
                since <= since + 1;
            end
        end
    end

    // R2: off period lasts exactly OFF_CYC cycles
    a_r2_off_len: assert property (@(posedge clk) disable iff (rst)
        (prev_off && phase != PH_OFF) |-> (off_run == OFF_CYC));

    // R2: a comparator hit while conducting starts an off period
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && over_lim && !short_det) |=> (force_off && lim_active));

    // R3: blanking never leads straight into an off period
    a_r3_blank_mask: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BLANK) |=> (phase != PH_OFF));

    // R4: chopping rate cap
    a_r4_min_gap: assert property (@(posedge clk) disable iff (rst)
        (entry && seen_start) |-> (since >= GAP));

    // R5: every fault pulse comes from the short-circuit flag
    a_r5_fault_src: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> $past(short_det));

    // R6: short-circuit forces off on the next cycle
    a_r6_short_off: assert property (@(posedge clk) disable iff (rst)
        short_det |=> force_off);

    // R6: fault pulse is a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |=> !fault_pulse);

    // R8: short-circuit blocks a chop start
    a_r8_no_chop: assert property (@(posedge clk) disable iff (rst)
        (short_det && phase == PH_RUN) |=> (phase == PH_RUN && !lim_active));

    // R9: saturation
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        ((&evt_count) && !cnt_clr) |=> (&evt_count));

    // R10: clear without a start zeroes the count
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (cnt_clr && phase != PH_RUN) |=> (evt_count == '0));

endmodule

bind ilim_chopper ilim_chopper_chk #(
    .OFF_CYC  (OFF_CYC),
    .BLANK_CYC(BLANK_CYC),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .over_lim   (over_lim),
    .short_det  (short_det),
    .cnt_clr    (cnt_clr),
    .force_off  (force_off),
    .lim_active (lim_active),
    .fault_pulse(fault_pulse),
    .evt_count  (evt_count),
    .phase      (phase)
);

// File: tb/sim_ilim_chopper.sv
`timescale 1ns/1ps
module sim_ilim_chopper;
    localparam int OFF   = 20;
    localparam int BLANK = 12;
    localparam int CW    = 3;
    localparam int MAXC  = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          over_lim = 1'b0;
    logic          short_det = 1'b0;
    logic          cnt_clr = 1'b0;
    logic          force_off;
    logic          lim_active;
    logic          fault_pulse;
    logic [CW-1:0] evt_count;

    int checks = 0;
    int fails = 0;
    int nfault = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    ilim_chopper #(
        .OFF_CYC  (OFF),
        .BLANK_CYC(BLANK),
        .CNT_W    (CW)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .over_lim   (over_lim),
        .short_det  (short_det),
        .cnt_clr    (cnt_clr),
        .force_off  (force_off),
        .lim_active (lim_active),
        .fault_pulse(fault_pulse),
        .evt_count  (evt_count)
    );

    always @(posedge clk) if (fault_pulse) nfault++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int bump(input int c);
        return (c >= MAXC) ? MAXC : c + 1;
    endfunction

    task automatic t_reset;
        rst = 1'b1;
        adv(3);
        chk("R1", "force_off in reset", force_off, 0);
        rst = 1'b0;
        adv(1);
        chk("R1", "force_off", force_off, 0);
        chk("R1", "lim_active", lim_active, 0);
        chk("R1", "fault_pulse", fault_pulse, 0);
        chk("R1", "evt_count", evt_count, 0);
    endtask

    task automatic t_single_chop;
        int f0;
        f0 = nfault;
        over_lim = 1'b1;
        adv(1);
        over_lim = 1'b0;
        exp_cnt = bump(exp_cnt);
        chk("R2", "force_off first cycle", force_off, 1);
        chk("R2", "lim_active first cycle", lim_active, 1);
        chk("R9", "count after start", evt_count, exp_cnt);
        adv(OFF - 1);
        chk("R2", "force_off last off cycle", force_off, 1);
        adv(1);
        chk("R2", "force_off after off time", force_off, 0);
        chk("R3", "lim_active in blanking", lim_active, 1);
        adv(BLANK - 1);
        chk("R3", "lim_active last blank cycle", lim_active, 1);
        adv(1);
        chk("R3", "lim_active after blanking", lim_active, 0);
        adv(2);
        chk("R5", "no fault from chopping", nfault, f0);
    endtask

    task automatic t_blank_ignore;
        over_lim = 1'b1;
        adv(1);
        over_lim = 1'b0;
        exp_cnt = bump(exp_cnt);
        adv(OFF);
        over_lim = 1'b1;
        adv(BLANK - 1);
        chk("R3", "force_off while comparator high in blanking", force_off, 0);
        over_lim = 1'b0;
        adv(2);
        chk("R3", "no restart from blanking hit", force_off, 0);
        chk("R3", "lim_active idle", lim_active, 0);
        chk("R3", "count unchanged by blanking hit", evt_count, exp_cnt);
    endtask

    task automatic t_back_to_back;
        int f0;
        f0 = nfault;
        over_lim = 1'b1;
        adv(1);
        exp_cnt = bump(exp_cnt);
        chk("R4", "first start", force_off, 1);
        adv(OFF + BLANK);
        chk("R4", "conducting cycle force_off", force_off, 0);
        chk("R4", "conducting cycle lim_active", lim_active, 0);
        adv(1);
        exp_cnt = bump(exp_cnt);
        chk("R4", "restart after one conducting cycle", force_off, 1);
        chk("R9", "count after two starts", evt_count, exp_cnt);
        over_lim = 1'b0;
        adv(OFF + BLANK + 2);
        chk("R4", "idle after chop pair", lim_active, 0);
        chk("R5", "no fault from back-to-back chops", nfault, f0);
    endtask

    task automatic t_short_idle;
        int f0;
        f0 = nfault;
        short_det = 1'b1;
        over_lim  = 1'b1;
        adv(1);
        chk("R6", "force_off next cycle", force_off, 1);
        chk("R6", "fault_pulse high", fault_pulse, 1);
        chk("R8", "no chop while short", lim_active, 0);
        adv(1);
        chk("R6", "fault_pulse single cycle", fault_pulse, 0);
        chk("R6", "force_off held", force_off, 1);
        short_det = 1'b0;
        over_lim  = 1'b0;
        adv(1);
        chk("R6", "force_off released", force_off, 0);
        chk("R8", "lim_active still low", lim_active, 0);
        chk("R8", "count unchanged", evt_count, exp_cnt);
        chk("R6", "one fault pulse", nfault, f0 + 1);
    endtask

    task automatic t_short_in_off;
        int f0;
        f0 = nfault;
        over_lim = 1'b1;
        adv(1);
        over_lim = 1'b0;
        exp_cnt = bump(exp_cnt);
        adv(4);
        short_det = 1'b1;
        adv(1);
        chk("R7", "fault_pulse during off period", fault_pulse, 1);
        adv(1);
        short_det = 1'b0;
        adv(OFF - 7);
        chk("R7", "force_off last off cycle", force_off, 1);
        adv(1);
        chk("R7", "off period not extended", force_off, 0);
        chk("R7", "blanking follows", lim_active, 1);
        adv(BLANK + 1);
        chk("R7", "exactly one fault pulse", nfault, f0 + 1);
        chk("R7", "count one start", evt_count, exp_cnt);
    endtask

    task automatic t_clear;
        cnt_clr = 1'b1;
        adv(1);
        cnt_clr = 1'b0;
        exp_cnt = 0;
        chk("R10", "clear strobe", evt_count, 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < MAXC + 2; i++) begin
            over_lim = 1'b1;
            adv(1);
            over_lim = 1'b0;
            exp_cnt = bump(exp_cnt);
            adv(OFF + BLANK + 1);
        end
        chk("R9", "saturated count", evt_count, MAXC);
    endtask

    task automatic t_clear_and_start;
        over_lim = 1'b1;
        cnt_clr  = 1'b1;
        adv(1);
        over_lim = 1'b0;
        cnt_clr  = 1'b0;
        exp_cnt = 1;
        chk("R10", "clear with start", evt_count, 1);
        adv(OFF + BLANK + 2);
    endtask

    initial begin
        #4000000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        adv(1);
        t_reset();
        t_single_chop();
        t_blank_ignore();
        t_back_to_back();
        t_short_idle();
        t_short_in_off();
        t_clear();
        t_saturate();
        t_clear_and_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule